// File: doc/BRIEF.md
# Limit Timer with Stoppable User Counter

This block is a memory-mapped timer/counter for a 32-bit register bus. The bus carries a three-bit word index, separate read and write strobes, and write data. Read data is returned combinationally in the cycle the read strobe is high. A one-cycle `tick_en` pulse, nominally every 500 ns, advances the count. The count sits at bit 9 of the register word, so bits 8..0 of any count readout are zero.

In system mode the counter climbs toward a programmable limit. When the next tick would reach the limit, the count returns to zero and a sticky reached flag is set. The interrupt line follows that flag. Software acknowledges the interrupt by reading the limit word, which also restarts the count. In user mode the same counter runs freely under software start/stop control and never interrupts. It is read out as a high word and a low word. An instance built as the system-wide timer stays in system mode permanently.

Top module: `limit_timer`

## Requirements
- R1: After reset the limit and count are zero, the reached flag and `irq` are low, the counter is stopped (word 3 reads 1) and the mode is system (word 4 reads 0).
- R2: In system mode each tick adds 1 at bit 9 of the count. A read of word 1 returns the count in bits 30..0, with bits 8..0 always zero, and the reached flag in bit 31.
- R3: In system mode, a tick that brings the tick count up to limit>>9 reloads the count with zero and sets the reached flag. The flag stays set on later ticks until it is acknowledged. `irq` is high one cycle after the flag is set.
- R4: A write to word 0 stores bits 30..0 of the data as the limit and clears the count. A write of 0 to word 0 or word 2 stores 0x7FFFFFFF.
- R5: A write to word 2 stores the limit in the same way as word 0 but keeps the running count. Later wrap-around uses the new limit.
- R6: In system mode a read of word 0 returns the limit, clears the reached flag, drops `irq` and zeroes the count. If a tick arrives in the same cycle, the read wins.
- R7: Bit 0 of a write to word 4 selects the mode (1 = user, 0 = system). Word 4 reads back the mode in bit 0.
- R8: In user mode, bit 0 of a write to word 3 stops the counter (1) or resumes it (0). The count is held while the counter is stopped. Word 3 reads the stopped state. Writes to word 3 in system mode do not change it.
- R9: In user mode, word 0 reads the tick count shifted right by (limit width − 9), and word 1 reads the tick count shifted left by 9. These reads have no side effect.
- R10: In user mode `irq` is never asserted, even when the count passes the limit.
- R11: An instance with `SYS_WIDE` set ignores writes to word 4 and stays in system mode.
- R12: Reads of words 2, 5, 6 and 7 return zero. Writes to words 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count enable, one per 500 ns |
| bus_word | input | 3 | Word index of the access (byte address bits 4..2) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects apply at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, zero otherwise |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench targets the following corner cases:

- **Wrap cycle.** A design with an off-by-one compare would wrap a tick early or late, and the count read just before and after the wrap would be wrong.
- **Acknowledging read coinciding with a wrapping tick.** If the tick were given priority, the reached flag would be left set.
- **Lowering the limit through word 2.** The next wrap must happen at the new limit and must not clear the count.
- **Zero-limit substitution.** A missing substitution would show up when the limit is read back.
- **User mode.** A stopped counter must hold its count, a word 0 read must not restart it, the counter must pass the limit without an interrupt, and a narrow-limit instance must carry into the high word.
- **Address decoding.** Decoding only two address bits would let word 7 alias the start/stop word.
- **Hard-wired system-wide instance.** Such an instance must ignore mode writes.

// File: rtl/limit_timer_pkg.sv
`timescale 1ns/1ps
package limit_timer_pkg;

    // word indices; the acknowledge and reload behaviour hangs on these
    localparam logic [2:0] WORD_LIMIT    = 3'd0;
    localparam logic [2:0] WORD_COUNT    = 3'd1;
    localparam logic [2:0] WORD_LIMIT_NC = 3'd2;
    localparam logic [2:0] WORD_RUN      = 3'd3;
    localparam logic [2:0] WORD_MODE     = 3'd4;

    typedef struct packed {
        logic limit;
        logic count;
        logic limit_nc;
        logic run;
        logic mode;
    } word_sel_t;

endpackage

// File: rtl/limit_timer_decode.sv
`timescale 1ns/1ps
module limit_timer_decode
    import limit_timer_pkg::*;
(
    input  logic [2:0] word_i,
    output word_sel_t  sel_o
);
    always_comb begin
        sel_o          = '0;
        sel_o.limit    = (word_i == WORD_LIMIT);
        sel_o.count    = (word_i == WORD_COUNT);
        sel_o.limit_nc = (word_i == WORD_LIMIT_NC);
        sel_o.run      = (word_i == WORD_RUN);
        sel_o.mode     = (word_i == WORD_MODE);
    end
endmodule

// File: rtl/limit_timer_step.sv
`timescale 1ns/1ps
module limit_timer_step #(
    parameter int EXT_W = 53,
    parameter int TCK_W = 22
) (
    input  logic [EXT_W-1:0] cnt_i,
    input  logic [TCK_W-1:0] lim_tck_i,
    input  logic             wrap_i,
    output logic [EXT_W-1:0] cnt_o,
    output logic             hit_o
);
    logic [EXT_W-1:0] inc;

    always_comb begin
        inc   = cnt_i + EXT_W'(1);
        hit_o = wrap_i && (inc >= EXT_W'(lim_tck_i));
        cnt_o = hit_o ? '0 : inc;
    end
endmodule

// File: rtl/limit_timer_rdmux.sv
`timescale 1ns/1ps
module limit_timer_rdmux
    import limit_timer_pkg::*;
#(
    parameter int LIM_W = 31,
    parameter int FRAC  = 9,
    parameter int EXT_W = 53
) (
    input  logic             rd_i,
    input  word_sel_t        sel_i,
    input  logic             user_i,
    input  logic             reached_i,
    input  logic             stopped_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic [EXT_W-1:0] cnt_i,
    output logic [31:0]      rdata_o
);
    localparam int          HI_SH = LIM_W - FRAC;
    localparam logic [31:0] CMASK = (32'd1 << LIM_W) - 32'd1;

    logic [31:0] low_word;
    logic [30:0] high_word;

    always_comb begin
        low_word  = {cnt_i[31-FRAC:0], {FRAC{1'b0}}};
        high_word = cnt_i[EXT_W-1:HI_SH];
        rdata_o   = '0;
        if (rd_i) begin
            if (sel_i.limit)
                rdata_o = user_i ? {1'b0, high_word} : 32'(limit_i);
            else if (sel_i.count)
                rdata_o = user_i ? low_word
                                 : {reached_i, low_word[30:0] & CMASK[30:0]};
            else if (sel_i.run)
                rdata_o = {31'd0, stopped_i};
            else if (sel_i.mode)
                rdata_o = {31'd0, user_i};
        end
    end
endmodule

// File: rtl/limit_timer.sv
`timescale 1ns/1ps
module limit_timer
    import limit_timer_pkg::*;
#(
    parameter int LIM_W    = 31,
    parameter int FRAC     = 9,
    parameter bit SYS_WIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [2:0]  bus_word,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int          TCK_W    = LIM_W - FRAC;
    localparam int          EXT_W    = TCK_W + 31;
    localparam logic [31:0] LIM_ONES = (32'd1 << LIM_W) - 32'd1;

    typedef struct packed {
        logic [LIM_W-1:0] limit;
        logic [EXT_W-1:0] cnt;
        logic             reached;
        logic             stopped;
        logic             user;
        logic             irq;
    } state_t;

    state_t           st_d, st_q;
    word_sel_t        sel;
    logic [LIM_W-1:0] limit_nx;
    logic [EXT_W-1:0] step_cnt;
    logic             step_hit;
    logic             wr_limit, advance, ack;

    // plain views of state for the bound checker
    logic user_q, reached_q, stopped_q;
    assign user_q    = st_q.user;
    assign reached_q = st_q.reached;
    assign stopped_q = st_q.stopped;

    limit_timer_decode u_dec (
        .word_i (bus_word),
        .sel_o  (sel)
    );

    always_comb begin
        wr_limit = bus_wr && (sel.limit || sel.limit_nc);
        limit_nx = st_q.limit;
        if (wr_limit)
            limit_nx = (bus_wdata == 32'd0) ? LIM_ONES[LIM_W-1:0]
                                            : bus_wdata[LIM_W-1:0];
    end

    limit_timer_step #(.EXT_W(EXT_W), .TCK_W(TCK_W)) u_step (
        .cnt_i     (st_q.cnt),
        .lim_tck_i (limit_nx[LIM_W-1:FRAC]),
        .wrap_i    (!st_q.user),
        .cnt_o     (step_cnt),
        .hit_o     (step_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.limit = limit_nx;
        advance    = tick_en && (!st_q.user || !st_q.stopped);
        ack        = bus_rd && sel.limit && !st_q.user;

        if (advance) begin
            st_d.cnt = step_cnt;
            if (step_hit)
                st_d.reached = 1'b1;
        end
        if (bus_wr && sel.limit)
            st_d.cnt = '0;
        // acknowledge beats a same-cycle wrapping tick
        if (ack) begin
            st_d.cnt     = '0;
            st_d.reached = 1'b0;
        end
        if (bus_wr && sel.run && st_q.user)
            st_d.stopped = bus_wdata[0];
        if (bus_wr && sel.mode && !SYS_WIDE)
            st_d.user = bus_wdata[0];

        st_d.irq = st_d.reached && !st_d.user;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stopped <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    limit_timer_rdmux #(.LIM_W(LIM_W), .FRAC(FRAC), .EXT_W(EXT_W)) u_rd (
        .rd_i      (bus_rd),
        .sel_i     (sel),
        .user_i    (st_q.user),
        .reached_i (st_q.reached),
        .stopped_i (st_q.stopped),
        .limit_i   (st_q.limit),
        .cnt_i     (st_q.cnt),
        .rdata_o   (bus_rdata)
    );

    assign irq = st_q.irq;
endmodule

// File: rtl/limit_timer_chk.sv
`timescale 1ns/1ps
module limit_timer_chk #(
    parameter bit SYS_WIDE = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_word,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        irq,
    input logic        user_q,
    input logic        reached_q,
    input logic        stopped_q
);
    logic sys_ack;
    assign sys_ack = bus_rd && (bus_word == 3'd0) && !user_q;

    // R10
    user_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_q |-> !irq);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ack |=> (!irq && !reached_q));

    // R2
    frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_word == 3'd1) |-> (bus_rdata[8:0] == 9'd0));

    // R8
    run_ignored_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 3'd3 && !user_q) |=> $stable(stopped_q));

    // R11
    sys_wide_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 3'd4 && SYS_WIDE) |=> !user_q);

    // R3
    reached_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reached_q && !sys_ack) |=> reached_q);

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_word == 3'd2 || bus_word > 3'd4)) |-> (bus_rdata == 32'd0));
endmodule

bind limit_timer limit_timer_chk #(.SYS_WIDE(SYS_WIDE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_word  (bus_word),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .user_q    (user_q),
    .reached_q (reached_q),
    .stopped_q (stopped_q)
);

// File: tb/sim_limit_timer.sv
`timescale 1ns/1ps
module sim_limit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_word = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] rd0, rd1, rd2;
    logic        irq0, irq1, irq2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    limit_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_word(bus_word),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd0), .irq(irq0));

    // narrow limit: high word shift is 6, so it carries after 64 ticks
    limit_timer #(.LIM_W(15)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_word(bus_word),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd1), .irq(irq1));

    limit_timer #(.SYS_WIDE(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_word(bus_word),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd2), .irq(irq2));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_word = w; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int inst, input logic [2:0] w, output logic [31:0] v);
        @(negedge clk);
        bus_word = w; bus_rd = 1'b1;
        #1;
        v = (inst == 0) ? rd0 : (inst == 1) ? rd1 : rd2;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq0}, 32'd0);
        rd(0, 3'd1, v); check("R1 count", v, 32'd0);
        rd(0, 3'd3, v); check("R1 stopped", v, 32'd1);
        rd(0, 3'd4, v); check("R1 mode", v, 32'd0);
        rd(0, 3'd0, v); check("R1 limit", v, 32'd0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0A00);                // 5 ticks
        ticks(3);
        rd(0, 3'd1, v); check("R2 count 3", v, 32'h0000_0600);
        check("R3 no irq yet", {31'd0, irq0}, 32'd0);
        ticks(1);
        rd(0, 3'd1, v); check("R3 count 4", v, 32'h0000_0800);
        ticks(1);
        rd(0, 3'd1, v); check("R3 wrap sets flag", v, 32'h8000_0000);
        check("R3 irq", {31'd0, irq0}, 32'd1);
        ticks(1);
        rd(0, 3'd1, v); check("R3 sticky", v, 32'h8000_0200);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        rd(0, 3'd0, v); check("R6 limit read", v, 32'h0000_0A00);
        check("R6 irq dropped", {31'd0, irq0}, 32'd0);
        rd(0, 3'd1, v); check("R6 flag and count cleared", v, 32'd0);
    endtask

    task automatic t_nocl();
        logic [31:0] v;
        ticks(3);
        wr(3'd2, 32'h0000_1400);                // 10 ticks
        rd(0, 3'd1, v); check("R5 count kept", v, 32'h0000_0600);
        ticks(6);
        rd(0, 3'd1, v); check("R5 no early wrap", v, 32'h0000_1200);
        ticks(1);
        rd(0, 3'd1, v); check("R5 wrap at new limit", v, 32'h8000_0000);
        rd(0, 3'd0, v); check("R5 limit value", v, 32'h0000_1400);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(3'd0, 32'd0);
        rd(0, 3'd0, v); check("R4 zero limit", v, 32'h7FFF_FFFF);
        wr(3'd2, 32'h8000_0A00);
        rd(0, 3'd0, v); check("R4 bit31 dropped", v, 32'h0000_0A00);
        ticks(2);
        wr(3'd0, 32'h0000_0A00);
        rd(0, 3'd1, v); check("R4 write clears count", v, 32'd0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0400);                // 2 ticks
        ticks(1);
        @(negedge clk);
        bus_word = 3'd0; bus_rd = 1'b1; tick_en = 1'b1;
        #1; v = rd0;
        @(negedge clk);
        bus_rd = 1'b0; tick_en = 1'b0;
        check("R6 limit on collision", v, 32'h0000_0400);
        check("R6 irq low after collision", {31'd0, irq0}, 32'd0);
        rd(0, 3'd1, v); check("R6 read beats tick", v, 32'd0);
    endtask

    task automatic t_sysrun();
        logic [31:0] v;
        wr(3'd3, 32'd0);
        rd(0, 3'd3, v); check("R8 run write ignored in system", v, 32'd1);
    endtask

    task automatic t_user();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0400);
        wr(3'd4, 32'd1);
        rd(0, 3'd4, v); check("R7 mode user", v, 32'd1);
        ticks(3);
        rd(0, 3'd1, v); check("R8 stopped holds", v, 32'd0);
        wr(3'd3, 32'd0);
        rd(0, 3'd3, v); check("R8 running", v, 32'd0);
        ticks(5);
        rd(0, 3'd1, v); check("R9 low word", v, 32'h0000_0A00);
        rd(0, 3'd0, v); check("R9 high word", v, 32'd0);
        rd(0, 3'd1, v); check("R9 read no side effect", v, 32'h0000_0A00);
        wr(3'd3, 32'd1);
        ticks(4);
        rd(0, 3'd1, v); check("R8 stop preserves", v, 32'h0000_0A00);
        rd(0, 3'd3, v); check("R8 stopped status", v, 32'd1);
        wr(3'd3, 32'd0);
        ticks(65);
        rd(0, 3'd1, v); check("R9 low after 70", v, 32'h0000_8C00);
        check("R10 no irq past limit", {31'd0, irq0}, 32'd0);
        rd(1, 3'd0, v); check("R9 high word carry", v, 32'd1);
        rd(1, 3'd1, v); check("R9 narrow low word", v, 32'h0000_8C00);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd5, 32'd0);
        wr(3'd6, 32'd0);
        rd(0, 3'd3, v); check("R12 word7 no alias", v, 32'd0);
        rd(0, 3'd4, v); check("R12 mode intact", v, 32'd1);
        rd(0, 3'd5, v); check("R12 read word5", v, 32'd0);
        rd(0, 3'd6, v); check("R12 read word6", v, 32'd0);
        rd(0, 3'd7, v); check("R12 read word7", v, 32'd0);
        rd(0, 3'd2, v); check("R12 read word2", v, 32'd0);
    endtask

    task automatic t_syswide();
        logic [31:0] v;
        rd(2, 3'd4, v); check("R11 system-wide mode", v, 32'd0);
        wr(3'd4, 32'd0);
        rd(0, 3'd4, v); check("R7 back to system", v, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wrap();
        t_ack();
        t_nocl();
        t_zero();
        t_prio();
        t_sysrun();
        t_user();
        t_unmapped();
        t_syswide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule